// File: doc/BRIEF.md
# SDIO Card Interrupt Detector

This block senses an interrupt that an SDIO card raises on DAT1. It takes a sample only on card clock rising edges, and only while two conditions hold: the host port is in SD/MMC mode and card-interrupt detection is switched on. A sample counts only while the bus permits an interrupt. The permission depends on the bus width and on where the data path is in a transfer: idle, moving block data, card busy, or in the short pause after a block's end bit.

A qualifying low sample sets a sticky status flag. The flag is set whatever the enable says, so software can poll it. The CPU interrupt line is that flag masked by the enable. Software clears the flag with a one-cycle pulse. The block uses the transfer-phase indicators from the data path and nothing else from the rest of the port.

Top module: `sdio_irq_detect`

## Requirements
- R1: After reset, `irq_stat` and `cpu_irq` are both 0.
- R2: A DAT1 low sample has no effect unless `sd_mode` and `det_on` are both 1.
- R3: DAT1 is examined only in a `clk` cycle where `cclk_rise` is 1. A card interrupt is `dat1` = 0 in such a cycle. `irq_stat` shows the result in the following cycle.
- R4: With `bus_4bit` = 0 (1-bit bus), the window is open unless `blk_data` and `card_busy` are both 1.
- R5: With `bus_4bit` = 1, the window is open when `xfer_active` = 0 and both `blk_data` and `card_busy` are 0.
- R6: With `bus_4bit` = 1, a strobe that has `blk_end` = 1 opens a gap. The next GAP_CLKS strobes (2 by default) fall inside the window even while `xfer_active` = 1. The strobe after those is outside it.
- R7: With `bus_4bit` = 1, the window is closed whenever `blk_data` or `card_busy` is 1. This holds when idle and during the gap.
- R8: `irq_stat` stays set until a cycle with `clr_stat` = 1 clears it. A qualifying sample in the same cycle as the clear wins, and the flag stays set.
- R9: `irq_stat` is set whatever `irq_en` is. `cpu_irq` is 1 exactly when both `irq_stat` and `irq_en` are 1.
- R10: If `irq_stat` is cleared while DAT1 stays low and the window stays open, the next strobe sets it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sd_mode | input | 1 | Port is in SD/MMC mode |
| det_on | input | 1 | Card-interrupt detection switched on |
| irq_en | input | 1 | CPU interrupt enable |
| bus_4bit | input | 1 | 1 = 4-bit data bus, 0 = 1-bit bus |
| cclk_rise | input | 1 | One-cycle strobe marking a card clock rising edge |
| dat1 | input | 1 | Synchronised DAT1 level |
| xfer_active | input | 1 | A data transfer is in progress |
| blk_data | input | 1 | Block data or CRC occupies DAT lines |
| blk_end | input | 1 | Current strobe carries a block end bit |
| card_busy | input | 1 | Card busy signalling on the data lines |
| clr_stat | input | 1 | Software clear pulse for the status flag |
| irq_stat | output | 1 | Sticky card-interrupt status |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The inter-block gap of R6 is the hardest case to reach. It exists only for a few card clocks after an end bit, and only while a transfer is still flagged active. The stimulus first runs block-data strobes, then gives one strobe with the end marker. It then samples DAT1 low on each of the following strobes. Between those strobes it clears the flag without issuing a strobe, so each gap position is tested on its own. A third sample shows that the window has closed again.

// File: rtl/sdio_irq_pkg.sv
package sdio_irq_pkg;

  typedef enum logic {
    BUS_1BIT = 1'b0,
    BUS_4BIT = 1'b1
  } bus_width_e;

  // Narrow bus: only a simultaneous data block and busy state blocks sensing
  function automatic logic narrow_win(logic blk, logic busy);
    return !(blk && busy);
  endfunction

  // Wide bus: idle or inter-block gap, and DAT lines not carrying data/busy
  function automatic logic wide_win(logic xfer, logic gap, logic blk, logic busy);
    return (!xfer || gap) && !blk && !busy;
  endfunction

endpackage

// File: rtl/sdio_irq_gap.sv
module sdio_irq_gap #(
  parameter int GAP_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cclk_rise,
  input  logic blk_end,
  output logic gap_open
);
  localparam int CW = $clog2(GAP_CLKS + 1);

  logic [CW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '0;
    end else if (cclk_rise) begin
      if (blk_end)
        gap_cnt <= CW'(GAP_CLKS);
      else if (gap_cnt != '0)
        gap_cnt <= gap_cnt - CW'(1);
    end
  end

  assign gap_open = (gap_cnt != '0);

  AST_GAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_rise && blk_end |=> gap_cnt == CW'(GAP_CLKS)); // R6
  AST_GAP_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_rise && !blk_end && gap_open |=> gap_cnt == $past(gap_cnt) - CW'(1)); // R6
  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cclk_rise |=> $stable(gap_cnt)); // R6

endmodule

// File: rtl/sdio_irq_window.sv
module sdio_irq_window
  import sdio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_width_e bus_w,
  input  logic       xfer_active,
  input  logic       gap_open,
  input  logic       blk_data,
  input  logic       card_busy,
  output logic       win_open
);
  always_comb begin
    unique case (bus_w)
      BUS_4BIT: win_open = wide_win(xfer_active, gap_open, blk_data, card_busy);
      default:  win_open = narrow_win(blk_data, card_busy);
    endcase
  end

  AST_WIDE_DATA_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_w == BUS_4BIT) && (blk_data || card_busy) |-> !win_open); // R7
  AST_WIDE_XFER_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_w == BUS_4BIT) && xfer_active && !gap_open |-> !win_open); // R6

endmodule

// File: rtl/sdio_irq_status.sv
module sdio_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_hit,
  input  logic clr_stat,
  input  logic irq_en,
  output logic irq_stat,
  output logic cpu_irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq_stat <= 1'b0;
    else if (sample_hit)
      irq_stat <= 1'b1;
    else if (clr_stat)
      irq_stat <= 1'b0;
  end

  assign cpu_irq = irq_stat & irq_en;

  AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    sample_hit |=> irq_stat); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stat && !clr_stat |=> irq_stat); // R8
  AST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stat && !sample_hit |=> !irq_stat); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !cpu_irq); // R9

endmodule

// File: rtl/sdio_irq_detect.sv
module sdio_irq_detect
  import sdio_irq_pkg::*;
#(
  parameter int GAP_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sd_mode,
  input  logic det_on,
  input  logic irq_en,
  input  logic bus_4bit,
  input  logic cclk_rise,
  input  logic dat1,
  input  logic xfer_active,
  input  logic blk_data,
  input  logic blk_end,
  input  logic card_busy,
  input  logic clr_stat,
  output logic irq_stat,
  output logic cpu_irq
);
  logic       det_active;
  logic       gap_open;
  logic       win_open;
  logic       sample_hit;
  bus_width_e bus_w;

  assign bus_w      = bus_4bit ? BUS_4BIT : BUS_1BIT;
  assign det_active = sd_mode & det_on;
  assign sample_hit = det_active & cclk_rise & win_open & ~dat1;

  sdio_irq_gap #(.GAP_CLKS(GAP_CLKS)) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cclk_rise (cclk_rise),
    .blk_end   (blk_end),
    .gap_open  (gap_open)
  );

  sdio_irq_window u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_w       (bus_w),
    .xfer_active (xfer_active),
    .gap_open    (gap_open),
    .blk_data    (blk_data),
    .card_busy   (card_busy),
    .win_open    (win_open)
  );

  sdio_irq_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_hit (sample_hit),
    .clr_stat   (clr_stat),
    .irq_en     (irq_en),
    .irq_stat   (irq_stat),
    .cpu_irq    (cpu_irq)
  );

  AST_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_stat) |-> $past(sd_mode && det_on)); // R2
  AST_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_stat) |-> $past(cclk_rise && !dat1)); // R3

endmodule

// File: tb/tb_sdio_irq_detect.sv
module tb_sdio_irq_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sd_mode = 1'b0, det_on = 1'b0, irq_en = 1'b0, bus_4bit = 1'b0;
  logic cclk_rise = 1'b0, dat1 = 1'b1, xfer_active = 1'b0;
  logic blk_data = 1'b0, blk_end = 1'b0, card_busy = 1'b0, clr_stat = 1'b0;
  logic irq_stat, cpu_irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sdio_irq_detect dut (
    .clk(clk), .rst_n(rst_n), .sd_mode(sd_mode), .det_on(det_on),
    .irq_en(irq_en), .bus_4bit(bus_4bit), .cclk_rise(cclk_rise), .dat1(dat1),
    .xfer_active(xfer_active), .blk_data(blk_data), .blk_end(blk_end),
    .card_busy(card_busy), .clr_stat(clr_stat), .irq_stat(irq_stat),
    .cpu_irq(cpu_irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // one card-clock strobe; outputs reflect it at the following negedge
  task automatic strobe();
    cclk_rise = 1'b1;
    @(negedge clk);
    cclk_rise = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear();
    clr_stat = 1'b1;
    @(negedge clk);
    clr_stat = 1'b0;
    @(negedge clk);
  endtask

  task automatic quiet();
    sd_mode = 1'b1; det_on = 1'b1; irq_en = 1'b0; bus_4bit = 1'b0;
    dat1 = 1'b1; xfer_active = 1'b0; blk_data = 1'b0; blk_end = 1'b0;
    card_busy = 1'b0;
    clear();
  endtask

  task automatic t_reset();
    chk("R1 stat", irq_stat, 1'b0);
    chk("R1 irq", cpu_irq, 1'b0);
  endtask

  task automatic t_active();
    quiet();
    sd_mode = 1'b0; dat1 = 1'b0; strobe();
    chk("R2 not sd mode", irq_stat, 1'b0);
    sd_mode = 1'b1; det_on = 1'b0; strobe();
    chk("R2 detect off", irq_stat, 1'b0);
    det_on = 1'b1; strobe();
    chk("R2 active", irq_stat, 1'b1);
  endtask

  task automatic t_strobe();
    quiet();
    dat1 = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 no strobe", irq_stat, 1'b0);
    strobe();
    chk("R3 strobe low", irq_stat, 1'b1);
    clear(); dat1 = 1'b1; strobe();
    chk("R3 strobe high", irq_stat, 1'b0);
  endtask

  task automatic t_narrow();
    quiet();
    dat1 = 1'b0; blk_data = 1'b1; card_busy = 1'b1; strobe();
    chk("R4 blk and busy", irq_stat, 1'b0);
    card_busy = 1'b0; strobe();
    chk("R4 blk only", irq_stat, 1'b1);
    clear(); blk_data = 1'b0; card_busy = 1'b1; strobe();
    chk("R4 busy only", irq_stat, 1'b1);
  endtask

  task automatic t_wide_idle();
    quiet();
    bus_4bit = 1'b1; dat1 = 1'b0; strobe();
    chk("R5 idle", irq_stat, 1'b1);
    clear(); xfer_active = 1'b1; strobe();
    chk("R5 xfer active", irq_stat, 1'b0);
  endtask

  task automatic t_wide_closed();
    quiet();
    bus_4bit = 1'b1; dat1 = 1'b0; blk_data = 1'b1; strobe();
    chk("R7 idle blk", irq_stat, 1'b0);
    blk_data = 1'b0; card_busy = 1'b1; strobe();
    chk("R7 idle busy", irq_stat, 1'b0);
    card_busy = 1'b0; xfer_active = 1'b1; dat1 = 1'b1;
    blk_end = 1'b1; strobe(); blk_end = 1'b0;
    dat1 = 1'b0; card_busy = 1'b1; strobe();
    chk("R7 gap busy", irq_stat, 1'b0);
    card_busy = 1'b0;
    strobe(); strobe();
  endtask

  task automatic t_gap();
    quiet();
    bus_4bit = 1'b1; xfer_active = 1'b1; blk_data = 1'b1;
    dat1 = 1'b1; strobe(); strobe();
    blk_end = 1'b1; strobe(); blk_end = 1'b0; blk_data = 1'b0;
    dat1 = 1'b0; strobe();
    chk("R6 gap first", irq_stat, 1'b1);
    clear(); strobe();
    chk("R6 gap second", irq_stat, 1'b1);
    clear(); strobe();
    chk("R6 gap over", irq_stat, 1'b0);
  endtask

  task automatic t_sticky();
    quiet();
    dat1 = 1'b0; strobe(); dat1 = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 held", irq_stat, 1'b1);
    clear();
    chk("R8 cleared", irq_stat, 1'b0);
    dat1 = 1'b0; clr_stat = 1'b1; cclk_rise = 1'b1;
    @(negedge clk);
    clr_stat = 1'b0; cclk_rise = 1'b0;
    chk("R8 set beats clear", irq_stat, 1'b1);
    dat1 = 1'b1;
  endtask

  task automatic t_enable();
    quiet();
    dat1 = 1'b0; strobe(); dat1 = 1'b1;
    chk("R9 stat no enable", irq_stat, 1'b1);
    chk("R9 irq masked", cpu_irq, 1'b0);
    irq_en = 1'b1; @(negedge clk);
    chk("R9 irq raised", cpu_irq, 1'b1);
    clear();
    chk("R9 irq dropped", cpu_irq, 1'b0);
  endtask

  task automatic t_reset_again();
    quiet();
    dat1 = 1'b0; strobe();
    clear();
    chk("R10 cleared", irq_stat, 1'b0);
    strobe();
    chk("R10 set again", irq_stat, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_active();
    t_strobe();
    t_narrow();
    t_wide_idle();
    t_wide_closed();
    t_gap();
    t_sticky();
    t_enable();
    t_reset_again();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule